// File: doc/BRIEF.md
# Address Translation Cache with Page-Table Walk

This block translates logical addresses into physical addresses for one requester. A logical address is split into a page number (upper bits) and an in-page offset (lower bits). The page number is looked up in a small fully associative cache of recent translations. On a hit the physical address is the cached frame number with the original offset appended, and it is returned one cycle after the request is accepted. On a miss the block makes one read of the page table held in memory, at the entry that the page number indexes. If that entry is marked valid, the block returns the translation and caches it. If the entry is marked invalid, the block returns a fault.

A management port lets software write any cache slot directly. A slot written as wired ("pinned") is never chosen as a replacement victim. A flush input drops every unpinned translation in one cycle. Only one table walk is outstanding at a time, and the request side is held off until it finishes.

With the default parameters the logical address is 14 bits, pages are 2 KB (11-bit offset, 3-bit page number, so 8 pages), frames are 4 bits wide, and the cache has 4 slots.

Top module: `xlat_tlb`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, `req_ready`, `rsp_valid` and `mem_req` are 0. Once the internal reset is released, `req_ready` is 1.
- R2: The page number is `req_laddr[LA_W-1:OFF_W]` and the offset is `req_laddr[OFF_W-1:0]`. A successful response carries `rsp_paddr = {frame, offset}`, with the frame in the upper `FN_W` bits.
- R3: A request that hits a valid cached page gives `rsp_valid=1`, `rsp_hit=1` and `rsp_fault=0` in the cycle after acceptance, and it issues no memory read.
- R4: A miss raises `mem_req` with `mem_addr` equal to the page number. `mem_req` and `mem_addr` are held until `mem_rdy` is seen, and exactly one read is granted. `req_ready` stays 0 from acceptance until the response appears.
- R5: A page-table word `mem_rdata` carries the valid bit in bit `FN_W` and the frame in bits `FN_W-1:0`. If the valid bit is 1 when `mem_rvalid` arrives (after any number of wait cycles), the next cycle gives `rsp_valid=1` and `rsp_hit=0` with the translated address, and the mapping is cached, so a later request to that page hits.
- R6: If the returned valid bit is 0, the next cycle gives `rsp_valid=1`, `rsp_fault=1` and `rsp_paddr=0` for exactly one cycle. Nothing is cached, so a repeated request to that page walks again.
- R7: A new mapping goes into the lowest-index empty unpinned slot. When no slot is empty, it goes into the first unpinned slot at or after a round-robin pointer, and the pointer then moves to the slot after the victim. The pointer starts at slot 0.
- R8: A management write (`mg_we`) puts `mg_page` and `mg_frame` into slot `mg_slot` as a valid entry, pinned when `mg_pin=1`. A pinned entry is never replaced and keeps hitting across later misses.
- R9: If every slot is pinned, a miss still completes its walk and response, but nothing is cached.
- R10: `flush` invalidates every unpinned slot in one cycle. Pinned slots keep hitting.
- R11: `rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | LA_W | Logical address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response was served from the cache |
| rsp_fault | output | 1 | Page-table entry was invalid |
| rsp_paddr | output | FN_W+OFF_W | Physical address |
| mem_req | output | 1 | Page-table read request |
| mem_rdy | input | 1 | Memory accepts the read |
| mem_addr | output | LA_W-OFF_W | Page-table index (page number) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | FN_W+1 | Page-table word: valid bit and frame |
| mg_we | input | 1 | Management slot write |
| mg_slot | input | clog2(ENTRIES) | Slot to write |
| mg_page | input | LA_W-OFF_W | Page number for the slot |
| mg_frame | input | FN_W | Frame number for the slot |
| mg_pin | input | 1 | Pin the written slot against replacement |
| flush | input | 1 | Invalidate all unpinned slots |

## Verification
The hardest cases to reach from the ports are the replacement corners. One is a full cache whose round-robin pointer has to step over a pinned slot. The other is a cache in which every slot is pinned, so a valid walk must not cache anything. The stimulus first fills the cache through ordinary misses. It then pins a slot in the middle through the management port and forces a series of misses to distinct pages, which walks the pointer across the pinned slot. Finally it pins the remaining slots and issues the same miss twice. The reference model predicts hit or miss for every request, so an entry that is wrongly evicted or wrongly cached shows up as an unexpected table read or a missing one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // state of the table-walk sequencer
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_ASK  = 2'd1,
    WK_WAIT = 2'd2
  } wk_state_e;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] wir,
  input  logic [SLOT_W-1:0]  rr_ptr,
  output logic               vic_ok,
  output logic               vic_evict,
  output logic [SLOT_W-1:0]  vic_idx
);
  logic              free_ok;
  logic [SLOT_W-1:0] free_idx;
  logic              ev_ok;
  logic [SLOT_W-1:0] ev_idx;
  logic [SLOT_W:0]   pos;

  // lowest empty unpinned slot: scan downward, last assignment wins
  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i] && !wir[i]) begin
        free_ok  = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  // first unpinned slot at or after the round-robin pointer
  always_comb begin
    ev_ok  = 1'b0;
    ev_idx = '0;
    pos    = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      pos = {1'b0, rr_ptr} + (SLOT_W+1)'(k);
      if (pos >= (SLOT_W+1)'(ENTRIES)) pos = pos - (SLOT_W+1)'(ENTRIES);
      if (!wir[pos[SLOT_W-1:0]]) begin
        ev_ok  = 1'b1;
        ev_idx = pos[SLOT_W-1:0];
      end
    end
  end

  always_comb begin
    vic_ok    = free_ok | ev_ok;
    vic_evict = !free_ok && ev_ok;
    vic_idx   = free_ok ? free_idx : ev_idx;
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PN_W    = 3,
  parameter int unsigned FN_W    = 4,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   look_page,
  output logic              hit,
  output logic [FN_W-1:0]   hit_frame,
  input  logic              ins_en,
  input  logic [PN_W-1:0]   ins_page,
  input  logic [FN_W-1:0]   ins_frame,
  input  logic              flush,
  input  logic              mg_we,
  input  logic [SLOT_W-1:0] mg_slot,
  input  logic [PN_W-1:0]   mg_page,
  input  logic [FN_W-1:0]   mg_frame,
  input  logic              mg_pin
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] wir_q, wir_d;
  logic [PN_W-1:0]    pg_q [ENTRIES];
  logic [PN_W-1:0]    pg_d [ENTRIES];
  logic [FN_W-1:0]    fr_q [ENTRIES];
  logic [FN_W-1:0]    fr_d [ENTRIES];
  logic [SLOT_W-1:0]  rr_q, rr_d;
  logic               vic_ok, vic_evict;
  logic [SLOT_W-1:0]  vic_idx;
  logic               do_ins;
  logic               tbl_en;
  logic [ENTRIES-1:0] match;

  xlat_victim #(.ENTRIES(ENTRIES)) i_victim (
    .vld       (vld_q),
    .wir       (wir_q),
    .rr_ptr    (rr_q),
    .vic_ok    (vic_ok),
    .vic_evict (vic_evict),
    .vic_idx   (vic_idx)
  );

  // associative compare, lowest matching slot wins
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (pg_q[g] == look_page);
  end

  always_comb begin
    hit       = 1'b0;
    hit_frame = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit       = 1'b1;
        hit_frame = fr_q[i];
      end
    end
  end

  assign do_ins = ins_en && vic_ok;
  assign tbl_en = flush || do_ins || mg_we;

  // update order: flush, then install, then management write
  always_comb begin
    vld_d = vld_q;
    wir_d = wir_q;
    rr_d  = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      pg_d[i] = pg_q[i];
      fr_d[i] = fr_q[i];
    end
    if (flush) vld_d = vld_q & wir_q;
    if (do_ins) begin
      vld_d[vic_idx] = 1'b1;
      wir_d[vic_idx] = 1'b0;
      pg_d[vic_idx]  = ins_page;
      fr_d[vic_idx]  = ins_frame;
      if (vic_evict) begin
        rr_d = (vic_idx == SLOT_W'(ENTRIES - 1)) ? '0 : vic_idx + 1'b1;
      end
    end
    if (mg_we) begin
      vld_d[mg_slot] = 1'b1;
      wir_d[mg_slot] = mg_pin;
      pg_d[mg_slot]  = mg_page;
      fr_d[mg_slot]  = mg_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wir_q <= '0;
      rr_q  <= '0;
    end else if (tbl_en) begin
      vld_q <= vld_d;
      wir_q <= wir_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        pg_q[i] <= pg_d[i];
        fr_q[i] <= fr_d[i];
      end
    end
  end

  // R7: the chosen victim is never a pinned slot
  assert_victim_unpinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && vic_ok) |-> !wir_q[vic_idx]);

  // R9: with every slot pinned an install leaves the table untouched
  assert_all_pinned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && (&wir_q) && !mg_we && !flush) |=> ($stable(vld_q) && $stable(wir_q)));

  // R10: a lone flush leaves only pinned slots valid
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !ins_en && !mg_we) |=> ((vld_q & ~wir_q) == '0));

  // R8: a pinned slot keeps its mapping unless management rewrites it
  for (genvar g = 0; g < ENTRIES; g++) begin : g_pin_chk
    assert_pinned_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wir_q[g] && !(mg_we && mg_slot == SLOT_W'(g)))
        |=> (wir_q[g] && vld_q[g] && $stable(pg_q[g]) && $stable(fr_q[g])));
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned LA_W  = 14,
  parameter int unsigned OFF_W = 11,
  parameter int unsigned FN_W  = 4,
  localparam int unsigned PN_W  = LA_W - OFF_W,
  localparam int unsigned PA_W  = FN_W + OFF_W,
  localparam int unsigned PTE_W = FN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_req,
  input  logic             mem_rdy,
  output logic [PN_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic [PN_W-1:0]  look_page,
  input  logic             hit,
  input  logic [FN_W-1:0]  hit_frame,
  output logic             ins_en,
  output logic [PN_W-1:0]  ins_page,
  output logic [FN_W-1:0]  ins_frame
);
  wk_state_e        st_q, st_d;
  logic [PN_W-1:0]  pg_q, pg_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             cap_en;
  logic             rv_q, rv_d;
  logic             rh_q, rh_d;
  logic             rf_q, rf_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             pa_en;
  logic             accept;
  logic             pte_ok;
  logic [FN_W-1:0]  pte_frame;

  assign req_ready = rst_n && (st_q == WK_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_page = req_laddr[LA_W-1:OFF_W];
  assign pte_ok    = mem_rdata[FN_W];
  assign pte_frame = mem_rdata[FN_W-1:0];
  assign mem_req   = (st_q == WK_ASK);
  assign mem_addr  = pg_q;
  assign ins_page  = pg_q;
  assign ins_frame = pte_frame;

  always_comb begin
    st_d   = st_q;
    pg_d   = pg_q;
    off_d  = off_q;
    cap_en = 1'b0;
    rv_d   = 1'b0;
    rh_d   = 1'b0;
    rf_d   = 1'b0;
    pa_d   = pa_q;
    pa_en  = 1'b0;
    ins_en = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (accept) begin
          if (hit) begin
            rv_d  = 1'b1;
            rh_d  = 1'b1;
            pa_d  = {hit_frame, req_laddr[OFF_W-1:0]};
            pa_en = 1'b1;
          end else begin
            st_d   = WK_ASK;
            pg_d   = req_laddr[LA_W-1:OFF_W];
            off_d  = req_laddr[OFF_W-1:0];
            cap_en = 1'b1;
          end
        end
      end
      WK_ASK: begin
        if (mem_rdy) st_d = WK_WAIT;
      end
      WK_WAIT: begin
        if (mem_rvalid) begin
          st_d  = WK_IDLE;
          rv_d  = 1'b1;
          pa_en = 1'b1;
          if (pte_ok) begin
            ins_en = 1'b1;
            pa_d   = {pte_frame, off_q};
          end else begin
            rf_d = 1'b1;
            pa_d = '0;
          end
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE;
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rf_q <= 1'b0;
      pa_q <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      rh_q <= rh_d;
      rf_q <= rf_d;
      if (pa_en) pa_q <= pa_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      pg_q  <= pg_d;
      off_q <= off_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_fault = rf_q;
  assign rsp_paddr = pa_q;

  // R3: a cached page answers in the following cycle
  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && rsp_hit && !rsp_fault));

  // R4: an ungranted read request is held with a steady index
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

  // R6: the fault indication lasts one cycle
  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> !rsp_fault);

  // R5/R6: an install always goes with a successful, non-fault response
  assert_install_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> (rsp_valid && !rsp_fault && !rsp_hit));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned LA_W    = 14,
  parameter int unsigned OFF_W   = 11,
  parameter int unsigned FN_W    = 4,
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned PN_W   = LA_W - OFF_W,
  localparam int unsigned PA_W   = FN_W + OFF_W,
  localparam int unsigned PTE_W  = FN_W + 1,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req,
  input  logic              mem_rdy,
  output logic [PN_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  input  logic              mg_we,
  input  logic [SLOT_W-1:0] mg_slot,
  input  logic [PN_W-1:0]   mg_page,
  input  logic [FN_W-1:0]   mg_frame,
  input  logic              mg_pin,
  input  logic              flush
);
  logic            rst_n;
  logic [PN_W-1:0] look_page;
  logic            hit;
  logic [FN_W-1:0] hit_frame;
  logic            ins_en;
  logic [PN_W-1:0] ins_page;
  logic [FN_W-1:0] ins_frame;

  xlat_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  xlat_walker #(.LA_W(LA_W), .OFF_W(OFF_W), .FN_W(FN_W)) i_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_laddr  (req_laddr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .mem_req    (mem_req),
    .mem_rdy    (mem_rdy),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .look_page  (look_page),
    .hit        (hit),
    .hit_frame  (hit_frame),
    .ins_en     (ins_en),
    .ins_page   (ins_page),
    .ins_frame  (ins_frame)
  );

  xlat_cam #(.ENTRIES(ENTRIES), .PN_W(PN_W), .FN_W(FN_W)) i_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_page (look_page),
    .hit       (hit),
    .hit_frame (hit_frame),
    .ins_en    (ins_en),
    .ins_page  (ins_page),
    .ins_frame (ins_frame),
    .flush     (flush),
    .mg_we     (mg_we),
    .mg_slot   (mg_slot),
    .mg_page   (mg_page),
    .mg_frame  (mg_frame),
    .mg_pin    (mg_pin)
  );
endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  localparam int LA_W = 14, OFF_W = 11, FN_W = 4, ENT = 4;
  localparam int PN_W = LA_W - OFF_W, PA_W = FN_W + OFF_W;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LA_W-1:0] req_laddr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [PN_W-1:0] mem_addr;
  logic mem_rdy = 1'b0, mem_rvalid = 1'b0;
  logic [FN_W:0] mem_rdata = '0;
  logic mg_we = 1'b0, mg_pin = 1'b0, flush = 1'b0;
  logic [1:0] mg_slot = '0;
  logic [PN_W-1:0] mg_page = '0;
  logic [FN_W-1:0] mg_frame = '0;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  bit m_vld [ENT];
  bit m_wir [ENT];
  int m_pg  [ENT];
  int m_fr  [ENT];
  int m_rr;
  int pt_frame [8];
  bit pt_ok    [8];

  always #10 clk = ~clk;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
    .mem_rdy(mem_rdy), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mg_we(mg_we), .mg_slot(mg_slot),
    .mg_page(mg_page), .mg_frame(mg_frame), .mg_pin(mg_pin), .flush(flush)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int m_find(input int pg);
    int s = -1;
    for (int i = ENT - 1; i >= 0; i--) if (m_vld[i] && m_pg[i] == pg) s = i;
    return s;
  endfunction

  function automatic void m_install(input int pg, input int fr);
    int s = -1;
    for (int i = ENT - 1; i >= 0; i--) if (!m_vld[i] && !m_wir[i]) s = i;
    if (s < 0) begin
      for (int k = ENT - 1; k >= 0; k--) if (!m_wir[(m_rr + k) % ENT]) s = (m_rr + k) % ENT;
      if (s >= 0) m_rr = (s + 1) % ENT;
    end
    if (s >= 0) begin
      m_vld[s] = 1; m_wir[s] = 0; m_pg[s] = pg; m_fr[s] = fr;
    end
  endfunction

  // one translation, compared against the model on every cycle
  task automatic xlate(input int la, input int gap, input int lat);
    int pg = (la >> OFF_W) & 7;
    int off = la & ((1 << OFF_W) - 1);
    int s = m_find(pg);
    check(req_ready == 1'b1, "R4 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_laddr = LA_W'(la);
    @(negedge clk);
    req_valid = 1'b0;
    if (s >= 0) begin
      check(rsp_valid && rsp_hit && !rsp_fault, "R3 hit response", {rsp_valid, rsp_hit, rsp_fault}, 3'b110);
      check(rsp_paddr == PA_W'((m_fr[s] << OFF_W) | off), "R2 hit paddr", int'(rsp_paddr), (m_fr[s] << OFF_W) | off);
      check(!mem_req, "R3 no read on hit", int'(mem_req), 0);
    end else begin
      check(mem_req && mem_addr == PN_W'(pg), "R4 walk index", int'(mem_addr), pg);
      check(!req_ready && !rsp_valid, "R4 busy during walk", {req_ready, rsp_valid}, 0);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(mem_req && mem_addr == PN_W'(pg) && !req_ready, "R4 request held", int'(mem_req), 1);
      end
      mem_rdy = 1'b1;
      @(negedge clk);
      mem_rdy = 1'b0;
      check(!mem_req, "R4 single read", int'(mem_req), 0);
      for (int l = 0; l < lat; l++) begin
        @(negedge clk);
        check(!rsp_valid && !mem_req && !req_ready, "R5 waiting for data", int'(rsp_valid), 0);
      end
      mem_rvalid = 1'b1;
      mem_rdata = {pt_ok[pg], FN_W'(pt_frame[pg])};
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pt_ok[pg]) begin
        check(rsp_valid && !rsp_hit && !rsp_fault, "R5 walk response", {rsp_valid, rsp_hit, rsp_fault}, 3'b100);
        check(rsp_paddr == PA_W'((pt_frame[pg] << OFF_W) | off), "R2 walk paddr", int'(rsp_paddr), (pt_frame[pg] << OFF_W) | off);
        m_install(pg, pt_frame[pg]);
      end else begin
        check(rsp_valid && rsp_fault && rsp_paddr == '0, "R6 fault response", {rsp_valid, rsp_fault}, 3);
      end
    end
    @(negedge clk);
    check(!rsp_valid && !rsp_fault, "R11 single pulse", {rsp_valid, rsp_fault}, 0);
    check(req_ready, "R11 ready after response", int'(req_ready), 1);
  endtask

  task automatic mgw(input int slot, input int pg, input int fr, input bit pin);
    mg_we = 1'b1; mg_slot = 2'(slot); mg_page = PN_W'(pg); mg_frame = FN_W'(fr); mg_pin = pin;
    @(negedge clk);
    mg_we = 1'b0;
    m_vld[slot] = 1; m_wir[slot] = pin; m_pg[slot] = pg; m_fr[slot] = fr;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < ENT; i++) if (!m_wir[i]) m_vld[i] = 0;
  endtask

  // expects hit or miss by counting the walk it observes
  task automatic expect_walk(input int la, input bit walk, input string tag);
    int pg = (la >> OFF_W) & 7;
    bit will = (m_find(pg) < 0);
    check(will == walk, tag, int'(will), int'(walk));
    xlate(la, 1, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_wir[i] = 0; m_pg[i] = 0; m_fr[i] = 0; end
    m_rr = 0;
    for (int p = 0; p < 8; p++) begin pt_frame[p] = (p * 5 + 3) % 16; pt_ok[p] = (p < 6); end

    repeat (3) @(negedge clk);
    check(!req_ready && !rsp_valid && !mem_req, "R1 outputs in reset", {req_ready, rsp_valid, mem_req}, 0);
    arst_n = 1'b1;
    @(negedge clk);
    check(!req_ready && !rsp_valid && !mem_req, "R1 outputs after release", {req_ready, rsp_valid, mem_req}, 0);
    repeat (2) @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // R5 walk then R3 hit, R2 offset kept
    xlate((0 << OFF_W) | 11'h123, 0, 0);
    xlate((0 << OFF_W) | 11'h7ff, 0, 0);
    // R6 invalid pages 6 and 7, walked every time
    xlate((6 << OFF_W) | 11'h010, 2, 3);
    xlate((6 << OFF_W) | 11'h020, 0, 1);
    check(m_find(6) < 0, "R6 model keeps page out", 0, 0);
    xlate((7 << OFF_W) | 11'h555, 1, 0);
    // R7 fill free slots, then round-robin eviction
    xlate((1 << OFF_W) | 11'h001, 3, 2);
    xlate((2 << OFF_W) | 11'h002, 0, 4);
    xlate((3 << OFF_W) | 11'h003, 1, 1);
    expect_walk((4 << OFF_W) | 11'h004, 1, "R7 page4 miss evicts slot0");
    expect_walk((0 << OFF_W) | 11'h005, 1, "R7 page0 evicted");
    expect_walk((2 << OFF_W) | 11'h006, 0, "R7 page2 still cached");
    // R8 pin slot 2 and run misses across it
    mgw(2, 5, 4'hb, 1'b1);
    expect_walk((5 << OFF_W) | 11'h0aa, 0, "R8 pinned page hits");
    expect_walk((1 << OFF_W) | 11'h011, 1, "R8 miss page1");
    expect_walk((3 << OFF_W) | 11'h012, 1, "R8 miss page3");
    expect_walk((2 << OFF_W) | 11'h013, 1, "R8 miss page2");
    expect_walk((4 << OFF_W) | 11'h014, 1, "R8 miss page4");
    expect_walk((5 << OFF_W) | 11'h015, 0, "R8 pinned survives misses");
    // R10 flush
    do_flush();
    expect_walk((5 << OFF_W) | 11'h016, 0, "R10 pinned kept by flush");
    expect_walk((4 << OFF_W) | 11'h017, 1, "R10 unpinned dropped by flush");
    // R9 every slot pinned
    mgw(0, 0, 4'h1, 1'b1);
    mgw(1, 1, 4'h2, 1'b1);
    mgw(3, 3, 4'h4, 1'b1);
    expect_walk((0 << OFF_W) | 11'h100, 0, "R8 management entry hits");
    expect_walk((4 << OFF_W) | 11'h101, 1, "R9 miss with all pinned");
    expect_walk((4 << OFF_W) | 11'h102, 1, "R9 nothing cached");
    // unpin slot 3 by rewriting, it becomes the only victim
    mgw(3, 3, 4'h4, 1'b0);
    expect_walk((4 << OFF_W) | 11'h103, 1, "R7 unpinned slot taken");
    expect_walk((4 << OFF_W) | 11'h104, 0, "R7 install after unpin");
    expect_walk((3 << OFF_W) | 11'h105, 1, "R7 evicted rewritten slot");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule